// File: doc/BRIEF.md
# Six-Pin Bidirectional GPIO Port Controller

This block is a six-bit general-purpose I/O port that sits on a simple byte-wide register bus. It keeps three registers: an output latch, a per-pin direction mask, and a pull configuration register. From these it drives each pad's output value, output enable and pull-resistor enable. It samples the pad levels through a two-flop synchroniser, then returns them on the bus and forwards them to an external key-wakeup consumer.

A read of the latch offset returns a mix, chosen bit by bit by the direction mask. Output pins return the latch value and input pins return the synchronised level. This lets software preload the latch before it turns a pin into an output. Pull resistors can only be on for input pins.

One bit of the pull configuration register is a pin-function select. When it is set, pin 4 stops being a port pin. It becomes an output that carries the 4x bus clock, its pull is forced off and its key-wakeup level is held low.

The block has no state machine. Its only sequential state is the register file, the synchroniser stages, and a cycle counter used by the checks.

Top module: `pio_port_ctrl`

## Requirements
- R1: While reset is asserted, the latch, direction, pull and clock-select registers all hold 0. Every pin is then an input with its pull off, and every register offset reads 0x00.
- R2: A write with `bus_wr` high updates the addressed register at that clock edge. The latch is at offset 0x0 and the direction mask at offset 0x4, each using bits 5:0. Bits 7:6 of both ignore writes and read as 0.
- R3: At offset 0x0, read bit i returns latch bit i when direction bit i is 1. It returns the synchronised level of pin i when direction bit i is 0. Bits 7:6 read as 0.
- R4: Writing the latch works whatever the direction mask holds. Outside the override, `pin_out` equals the latch and `pin_oe` equals the direction mask.
- R5: `pin_pu[i]` is 1 only when pull bit i is 1 and direction bit i is 0. Making a pin an output removes its pull in the same cycle.
- R6: The pin levels seen on the offset-0x0 read path and on `kbd_level` are `pin_in` delayed by exactly two clock edges.
- R7: The pull register is at offset 0xB. Bits 5:0 are the per-pin pull enables, bit 6 ignores writes and reads 0, and bit 7 is the clock select. While bit 7 is 1, `pin_out[4]` follows `clk4x_in`, `pin_oe[4]` is 1, `pin_pu[4]` is 0 and `kbd_level[4]` is 0.
- R8: Reads of any offset other than 0x0, 0x4 and 0xB return 0x00. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| clk4x_in | input | 1 | 4x bus clock for the pin-4 override |
| pin_in | input | 6 | Pad input levels (asynchronous) |
| pin_out | output | 6 | Pad output values |
| pin_oe | output | 6 | Pad output enables |
| pin_pu | output | 6 | Pad pull-resistor enables |
| kbd_level | output | 6 | Synchronised pin levels for the key-wakeup logic |

## Verification
A corrupted latch or direction bit shows up on `pin_out`/`pin_oe` one edge after the write. It shows up on the offset-0x0 read at once. A wrong pull gate shows on `pin_pu` in the same cycle the direction changes. A synchroniser with the wrong depth shows up as a one-cycle slip on `kbd_level` and on the read path, two edges after any `pin_in` change. The reference model compares every output and the read data on every cycle. It also walks the read address across the mapped and unmapped offsets, so a decode fault appears within one cycle of that address being selected.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LATCH,
        SEL_DIR,
        SEL_PULL
    } reg_sel_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[k] <= '0;
                else        stage_q[k] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[k] <= '0;
                else        stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int                NPINS    = 6,
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] OFS_LATCH = 4'h0,
    parameter logic [ADDR_W-1:0] OFS_DIR   = 4'h4,
    parameter logic [ADDR_W-1:0] OFS_PULL  = 4'hB,
    parameter int                SEL_BIT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [NPINS-1:0]  pin_lvl,
    output logic [BUS_W-1:0]  rdata,
    output logic [NPINS-1:0]  latch_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  pull_q,
    output logic              clksel_q
);
    reg_sel_e sel;
    logic     unused_wbits;

    assign unused_wbits = ^wdata[BUS_W-1:NPINS];

    always_comb begin
        sel = SEL_NONE;
        if      (addr == OFS_LATCH) sel = SEL_LATCH;
        else if (addr == OFS_DIR)   sel = SEL_DIR;
        else if (addr == OFS_PULL)  sel = SEL_PULL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q  <= '0;
            dir_q    <= '0;
            pull_q   <= '0;
            clksel_q <= 1'b0;
        end else if (wr) begin
            unique case (sel)
                SEL_LATCH: latch_q <= wdata[NPINS-1:0];
                SEL_DIR:   dir_q   <= wdata[NPINS-1:0];
                SEL_PULL: begin
                    pull_q   <= wdata[NPINS-1:0];
                    clksel_q <= wdata[SEL_BIT];
                end
                SEL_NONE:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_LATCH: rdata[NPINS-1:0] = (latch_q & dir_q) | (pin_lvl & ~dir_q);
            SEL_DIR:   rdata[NPINS-1:0] = dir_q;
            SEL_PULL: begin
                rdata[NPINS-1:0] = pull_q;
                rdata[SEL_BIT]   = clksel_q;
            end
            SEL_NONE:  rdata = '0;
        endcase
    end

    // R2: a direction write lands on the next edge
    assert_dir_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_DIR) |=> dir_q == $past(wdata[NPINS-1:0]));

    // R8: writes to unmapped offsets leave the register file untouched
    assert_unmapped_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_NONE) |=> (latch_q == $past(latch_q) && dir_q == $past(dir_q)
                                     && pull_q == $past(pull_q) && clksel_q == $past(clksel_q)));
endmodule

// File: rtl/pio_pinmux.sv
module pio_pinmux #(
    parameter int NPINS   = 6,
    parameter int CLK_PIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] latch_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] pull_q,
    input  logic             clksel_q,
    input  logic             clk4x_in,
    input  logic [NPINS-1:0] lvl,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_pu,
    output logic [NPINS-1:0] kbd_level
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        if (i == CLK_PIN) begin : g_ovr
            always_comb begin
                if (clksel_q) begin
                    pin_out[i]   = clk4x_in;
                    pin_oe[i]    = 1'b1;
                    pin_pu[i]    = 1'b0;
                    kbd_level[i] = 1'b0;
                end else begin
                    pin_out[i]   = latch_q[i];
                    pin_oe[i]    = dir_q[i];
                    pin_pu[i]    = pull_q[i] & ~dir_q[i];
                    kbd_level[i] = lvl[i];
                end
            end
        end else begin : g_port
            always_comb begin
                pin_out[i]   = latch_q[i];
                pin_oe[i]    = dir_q[i];
                pin_pu[i]    = pull_q[i] & ~dir_q[i];
                kbd_level[i] = lvl[i];
            end
        end
    end

    // R5: a pin is never pulled while it drives
    assert_no_pull_on_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    // R7: clock select takes over the pin completely
    assert_clock_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clksel_q |-> (pin_oe[CLK_PIN] && !pin_pu[CLK_PIN] && !kbd_level[CLK_PIN]
                      && pin_out[CLK_PIN] == clk4x_in));
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
    import pio_pkg::*;
#(
    parameter int NPINS       = 6,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CLK_PIN     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              clk4x_in,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_pu,
    output logic [NPINS-1:0]  kbd_level
);
    logic [NPINS-1:0] sync_lvl;
    logic [NPINS-1:0] latch_q, dir_q, pull_q;
    logic             clksel_q;
    logic [1:0]       age_q;

    pio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl)
    );

    pio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .pin_lvl(sync_lvl), .rdata(bus_rdata), .latch_q(latch_q), .dir_q(dir_q),
        .pull_q(pull_q), .clksel_q(clksel_q)
    );

    pio_pinmux #(.NPINS(NPINS), .CLK_PIN(CLK_PIN)) u_mux (
        .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
        .clksel_q(clksel_q), .clk4x_in(clk4x_in), .lvl(sync_lvl), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .kbd_level(kbd_level)
    );

    // cycles since reset, saturating at 2, so the latency check never looks before reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    if (SYNC_STAGES == 2) begin : g_lat_chk
        // R6: sampled levels trail the pads by two edges
        assert_sync_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd2) |-> sync_lvl == $past(pin_in, 2));
    end
endmodule

// File: tb/pio_port_ctrl_bench.sv
module pio_port_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       clk4x_in = 1'b0;
    logic [5:0] pin_in = 6'b101010;
    logic [5:0] pin_out, pin_oe, pin_pu, kbd_level;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_port_ctrl u_pio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk4x_in(clk4x_in),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .kbd_level(kbd_level)
    );

    // behavioural reference model
    logic [5:0] m_latch, m_dir, m_pull, m_s1, m_s2;
    logic       m_sel;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_latch <= 0; m_dir <= 0; m_pull <= 0; m_sel <= 0; m_s1 <= 0; m_s2 <= 0;
        end else begin
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            if (bus_wr) begin
                if (bus_addr == 4'h0) m_latch <= bus_wdata[5:0];
                if (bus_addr == 4'h4) m_dir   <= bus_wdata[5:0];
                if (bus_addr == 4'hB) begin
                    m_pull <= bus_wdata[5:0];
                    m_sel  <= bus_wdata[7];
                end
            end
        end
    end

    function automatic logic [7:0] exp_rdata(input logic [3:0] a);
        logic [7:0] r = 8'h00;
        if (a == 4'h0) begin
            for (int i = 0; i < 6; i++) r[i] = m_dir[i] ? m_latch[i] : m_s2[i];
        end else if (a == 4'h4) begin
            r = {2'b00, m_dir};
        end else if (a == 4'hB) begin
            r = {m_sel, 1'b0, m_pull};
        end
        return r;
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        if (!rst_n)                      return "R1";
        if (a == 4'h0)                   return "R3";
        if (a == 4'h4)                   return "R2";
        if (a == 4'hB)                   return "R7";
        return "R8";
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [5:0] e_out, e_oe, e_pu, e_kbd;
            for (int i = 0; i < 6; i++) begin
                if (m_sel && i == 4) begin
                    e_out[i] = clk4x_in; e_oe[i] = 1'b1; e_pu[i] = 1'b0; e_kbd[i] = 1'b0;
                end else begin
                    e_out[i] = m_latch[i]; e_oe[i] = m_dir[i];
                    e_pu[i]  = m_pull[i] & ~m_dir[i]; e_kbd[i] = m_s2[i];
                end
            end
            chk(m_sel ? "R7" : "R4", "pin_out", {2'b00, pin_out}, {2'b00, e_out});
            chk(!rst_n ? "R1" : "R4", "pin_oe", {2'b00, pin_oe}, {2'b00, e_oe});
            chk(!rst_n ? "R1" : "R5", "pin_pu", {2'b00, pin_pu}, {2'b00, e_pu});
            chk("R6", "kbd_level", {2'b00, kbd_level}, {2'b00, e_kbd});
            chk(rd_tag(bus_addr), "bus_rdata", bus_rdata, exp_rdata(bus_addr));
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic sweep_reads();
        foreach (sweep_addrs[k]) begin
            @(negedge clk); #1;
            bus_addr = sweep_addrs[k];
        end
    endtask

    logic [3:0] sweep_addrs [6] = '{4'h0, 4'h4, 4'hB, 4'h1, 4'h7, 4'hF};

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle(3);
        sweep_reads();                       // R1: reset reads
        rst_n = 1'b1;
        idle(3);
        sweep_reads();
        wr(4'h0, 8'hFF);                     // R2: bits 7:6 dropped, R4 latch preload as input
        sweep_reads();
        wr(4'h4, 8'hCF);                     // R2/R3: pins 3:0 outputs
        bus_addr = 4'h0;
        for (int p = 0; p < 8; p++) begin    // R6: latency on several patterns
            pin_in = 6'(p * 13 + 5);
            idle(3);
        end
        pin_in = 6'b010101; idle(1); pin_in = 6'b101010; idle(1); pin_in = 6'b000000;
        idle(4);
        wr(4'hB, 8'h7F);                     // R5/R7: bit6 ignored, pulls on inputs only
        sweep_reads();
        wr(4'h4, 8'h30);                     // R5: pull removed on new outputs
        sweep_reads();
        wr(4'h0, 8'h15);
        wr(4'h7, 8'hFF);                     // R8: unmapped write
        wr(4'h1, 8'hAA);
        sweep_reads();
        wr(4'h4, 8'h00);
        wr(4'hB, 8'hBF);                     // R7: clock override on
        bus_addr = 4'h0;
        for (int t = 0; t < 16; t++) begin
            @(negedge clk); #1;
            clk4x_in = ~clk4x_in;
            if (t % 4 == 0) pin_in = ~pin_in;
        end
        sweep_reads();
        wr(4'hB, 8'h05);                     // R7: override released
        pin_in = 6'b111111;
        idle(4);
        sweep_reads();
        @(negedge clk); #1; rst_n = 1'b0;    // R1: second reset
        idle(2);
        sweep_reads();
        rst_n = 1'b1;
        idle(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule